// File: doc/BRIEF.md
# Byte Table-Lookup Translate Engine

This engine rewrites a run of bytes in memory through a 256-entry byte lookup table. Software, or a neighbouring controller, hands it three operands in one start cycle: where the byte run begins, how many bytes it holds, and where the lookup table sits. The engine then works through the run on its own. For each byte it reads the byte, uses its unsigned value as an index into the table, reads that table entry, and writes the entry back over the original byte. When the last byte has been rewritten it raises a one-cycle completion pulse.

The engine talks to memory through a single byte-wide port. A request is held for exactly one cycle. A read returns its data later with a valid strobe, after one or more cycles. A write needs no reply. At most one read is in flight at a time, so the three accesses for a byte always form a strict chain: the table read cannot start until the data byte has arrived, and the write carries the table entry that was just returned. Bytes are handled one at a time in rising address order. An empty run finishes at once and touches no memory. Start requests that arrive while a run is in progress are dropped.

Top module: `xlat_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low. A `start` taken while idle raises `busy` on the next cycle, and `busy` stays high until the cycle that carries `done`.
- R2: After a run of length L at address B with table base T, every byte at B+k (0 <= k < L) holds the byte that was stored at T + (original byte value). No byte outside B..B+L-1 changes.
- R3: Each byte costs exactly three accesses in this order: a read (`mem_we`=0) of B+k, a read of T+value, and a write (`mem_we`=1) of the table entry to B+k. A read request is never followed by another request in the next cycle. A run of length L issues exactly 3L requests.
- R4: Bytes are processed in ascending address order. Each read of the data byte targets the address one above the previous one, starting at B.
- R5: A start with length zero gives `done` in the cycle right after the start and issues no memory request.
- R6: A `start` seen while `busy` is high is ignored: its operands are never used, and it produces no extra `done`.
- R7: `done` is high for exactly one cycle per accepted start, and `busy` is low in the cycle after `done`.
- R8: The table address is the full-width sum T + value, with carry into the upper address bits. A table that straddles a 256-byte boundary is therefore read correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| start_buf | input | AW | Address of the first byte of the run |
| start_len | input | LW | Number of bytes in the run |
| start_tbl | input | AW | Base address of the 256-entry table |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request strobe, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read, valid with `mem_req` |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 8 | Read data |

## Verification
The bench runs a 256-byte run whose bytes cover every index value once. The table sits at an unaligned base that crosses a 256-byte boundary. A design that wraps the table address inside one page, or that indexes with a signed byte, writes wrong values over part of that run. Memory read latency cycles through one, two and three cycles. A design that takes the response on a fixed cycle, or issues the table read before the data byte arrives, shows up in the recorded access trace. Separate runs cover length zero, which must finish without any access; length one; and a start pulse during a run, which must not alter a second prepared region or add a completion pulse. Bytes just outside each run are compared too, so an off-by-one in the count shows up as a changed neighbour.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Sequencer states: one idle state, five per-byte steps, one completion state
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_WT_SRC,
    ST_RD_LUT,
    ST_WT_LUT,
    ST_WR_DST,
    ST_FIN
  } xlat_state_e;

  // Memory operation requested in the current cycle
  typedef enum logic [1:0] {
    OP_NONE,
    OP_RD_SRC,
    OP_RD_LUT,
    OP_WR_DST
  } xlat_op_e;

endpackage

// File: rtl/xlat_cursor.sv
module xlat_cursor #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_buf,
  input  logic [AW-1:0] ld_tbl,
  input  logic [LW-1:0] ld_len,
  input  logic [7:0]    idx,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] lut_addr,
  output logic          last
);

  localparam logic [LW-1:0] ONE = LW'(1);

  // Full-width table address: carry runs into the upper bits (no page wrap)
  function automatic logic [AW-1:0] lut_entry_addr(input logic [AW-1:0] base,
                                                   input logic [7:0]    i);
    return base + AW'(i);
  endfunction

  function automatic logic [AW-1:0] next_byte(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] cur_q;
  logic [AW-1:0] tbl_q;
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      tbl_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      cur_q <= ld_buf;
      tbl_q <= ld_tbl;
      rem_q <= ld_len;
    end else if (step) begin
      cur_q <= next_byte(cur_q);
      rem_q <= rem_q - ONE;
    end
  end

  assign cur_addr = cur_q;
  assign lut_addr = lut_entry_addr(tbl_q, idx);
  assign last     = (rem_q == ONE);

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr == $past(cur_addr) + AW'(1))); // R4
  AST_STEP_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q != '0)); // R2

endmodule

// File: rtl/xlat_bytes.sv
module xlat_bytes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_src,
  input  logic       cap_lut,
  input  logic [7:0] rdata,
  output logic [7:0] idx,
  output logic [7:0] val
);

  logic [7:0] idx_q;
  logic [7:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      val_q <= '0;
    end else begin
      if (cap_src) idx_q <= rdata;
      if (cap_lut) val_q <= rdata;
    end
  end

  assign idx = idx_q;
  assign val = val_q;

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_src && cap_lut)); // R3

endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
  import xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     len_zero,
  input  logic     last,
  input  logic     rsp_valid,
  output xlat_op_e op,
  output logic     cap_src,
  output logic     cap_lut,
  output logic     load,
  output logic     step,
  output logic     busy,
  output logic     done
);

  xlat_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        load    = 1'b1;
        state_d = len_zero ? ST_FIN : ST_RD_SRC;
      end
      ST_RD_SRC: state_d = ST_WT_SRC;
      ST_WT_SRC: if (rsp_valid) state_d = ST_RD_LUT;
      ST_RD_LUT: state_d = ST_WT_LUT;
      ST_WT_LUT: if (rsp_valid) state_d = ST_WR_DST;
      ST_WR_DST: state_d = last ? ST_FIN : ST_RD_SRC;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_RD_SRC: op = OP_RD_SRC;
      ST_RD_LUT: op = OP_RD_LUT;
      ST_WR_DST: op = OP_WR_DST;
      default:   op = OP_NONE;
    endcase
  end

  assign cap_src = (state_q == ST_WT_SRC) && rsp_valid;
  assign cap_lut = (state_q == ST_WT_LUT) && rsp_valid;
  assign step    = (state_q == ST_WR_DST);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);

  AST_TAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R1
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_zero) |=> done); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7

endmodule

// File: rtl/xlat_engine.sv
module xlat_engine
  import xlat_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_buf,
  input  logic [LW-1:0] start_len,
  input  logic [AW-1:0] start_tbl,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata
);

  // Named internal events, brought out for the assertions
  xlat_op_e      op;
  logic          cap_src, cap_lut, load, step, last;
  logic          len_zero;
  logic [7:0]    idx, val;
  logic [AW-1:0] cur_addr, lut_addr;

  assign len_zero = (start_len == '0);

  xlat_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_zero  (len_zero),
    .last      (last),
    .rsp_valid (mem_rvalid),
    .op        (op),
    .cap_src   (cap_src),
    .cap_lut   (cap_lut),
    .load      (load),
    .step      (step),
    .busy      (busy),
    .done      (done)
  );

  xlat_cursor #(.AW(AW), .LW(LW)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .ld_buf   (start_buf),
    .ld_tbl   (start_tbl),
    .ld_len   (start_len),
    .idx      (idx),
    .cur_addr (cur_addr),
    .lut_addr (lut_addr),
    .last     (last)
  );

  xlat_bytes u_bytes (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_src (cap_src),
    .cap_lut (cap_lut),
    .rdata   (mem_rdata),
    .idx     (idx),
    .val     (val)
  );

  always_comb begin
    case (op)
      OP_RD_LUT: mem_addr = lut_addr;
      default:   mem_addr = cur_addr;
    endcase
  end

  assign mem_req   = (op != OP_NONE);
  assign mem_we    = (op == OP_WR_DST);
  assign mem_wdata = val;

  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req); // R3
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R3
  AST_WRITE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (done || (mem_req && !mem_we))); // R4

endmodule

// File: tb/xlat_engine_bench.sv
`timescale 1ns/1ps
module xlat_engine_bench;
  localparam int AW = 12;
  localparam int LW = 12;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] start_buf, start_tbl;
  logic [LW-1:0] start_len;
  logic          busy, done, mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  xlat_engine #(.AW(AW), .LW(LW)) u_xlat_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_buf(start_buf),
    .start_len(start_len), .start_tbl(start_tbl), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [7:0]    mem    [MEMSZ];
  logic [7:0]    shadow [MEMSZ];
  logic [7:0]    src_v  [1024];
  logic [AW-1:0] log_addr [4096];
  logic          log_we   [4096];
  logic [7:0]    log_wd   [4096];
  int n_log = 0;
  int n_done = 0;
  int n_cmp = 0;
  int n_bad = 0;

  // Memory model: sampled on the falling edge, read latency cycles 1..3
  logic       pend = 1'b0;
  int         pend_cnt = 0;
  logic [7:0] pend_data = '0;
  int         lat_sel = 0;

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pend_data;
        pend       = 1'b0;
      end else pend_cnt--;
    end
    if (done) n_done++;
    if (rst_n && mem_req) begin
      if (n_log < 4096) begin
        log_addr[n_log] = mem_addr;
        log_we[n_log]   = mem_we;
        log_wd[n_log]   = mem_wdata;
        n_log++;
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        pend      = 1'b1;
        pend_data = mem[mem_addr];
        pend_cnt  = lat_sel;
        lat_sel   = (lat_sel + 1) % 3;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] tbl_fn(input int mode, input int i);
    if (mode == 0) return 8'(i ^ 'hC0);
    return 8'(i * 37 + 11);
  endfunction

  task automatic fill_tbl(input logic [AW-1:0] base, input int mode);
    for (int i = 0; i < 256; i++) mem[AW'(base + i)] = tbl_fn(mode, i);
  endtask

  task automatic prep(input logic [AW-1:0] b, input int len, input logic [AW-1:0] t);
    for (int a = 0; a < MEMSZ; a++) shadow[a] = mem[a];
    for (int k = 0; k < len; k++) begin
      src_v[k] = mem[AW'(b + k)];
      shadow[AW'(b + k)] = mem[AW'(t + src_v[k])];
    end
    n_log = 0;
  endtask

  task automatic kick(input logic [AW-1:0] b, input int len, input logic [AW-1:0] t);
    @(posedge clk); #1;
    start = 1'b1; start_buf = b; start_len = LW'(len); start_tbl = t;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    chk("R1 busy after accepted start", busy, 1);
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R1 watchdog: done never seen", 0, 1);
    @(negedge clk);
    chk("R7 done lasts one cycle", done, 0);
    chk("R7 busy low after done", busy, 0);
  endtask

  task automatic verify(input logic [AW-1:0] b, input int len, input logic [AW-1:0] t);
    int outside = 0, order_bad = 0, trace_bad = 0;
    logic [AW-1:0] ea;
    for (int k = 0; k < len; k++)
      chk($sformatf("R2 byte at %0h", AW'(b + k)), mem[AW'(b + k)], shadow[AW'(b + k)]);
    for (int a = 0; a < MEMSZ; a++)
      if (mem[a] != shadow[a]) begin
        ea = AW'(a - b);
        if (int'(ea) >= len) outside++;
      end
    chk("R2 bytes outside run changed", outside, 0);
    chk("R3 request count", n_log, 3 * len);
    for (int k = 0; k < len && 3 * k + 2 < n_log; k++) begin
      if (log_we[3*k] || log_addr[3*k] != AW'(b + k)) order_bad++;
      ea = AW'(t + src_v[k]);
      if (log_we[3*k+1] || log_addr[3*k+1] != ea) trace_bad++;
      if (!log_we[3*k+2] || log_addr[3*k+2] != AW'(b + k) ||
          log_wd[3*k+2] != shadow[AW'(b + k)]) trace_bad++;
    end
    chk("R4 data reads not ascending from start", order_bad, 0);
    chk("R3 access chain order", trace_bad, 0);
  endtask

  initial begin
    int d0;
    rst_n = 1'b0; start = 1'b0; start_buf = '0; start_len = '0; start_tbl = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'(a * 3 ^ 'h5A);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset mem_req", mem_req, 0);
    rst_n = 1'b1;

    // Worked example: table maps F0..F9 to 30..39
    fill_tbl(12'h100, 0);
    mem[12'h210] = 8'hF1; mem[12'h211] = 8'hF9;
    mem[12'h212] = 8'hF8; mem[12'h213] = 8'hF4;
    prep(12'h210, 4, 12'h100);
    kick(12'h210, 4, 12'h100);
    wait_done();
    verify(12'h210, 4, 12'h100);
    chk("R2 example byte 0", mem[12'h210], 8'h31);
    chk("R2 example byte 1", mem[12'h211], 8'h39);
    chk("R2 example byte 2", mem[12'h212], 8'h38);
    chk("R2 example byte 3", mem[12'h213], 8'h34);

    // Sweep: all 256 index values, unaligned table crossing a page (R8)
    fill_tbl(12'h9C3, 1);
    for (int k = 0; k < 256; k++) mem[AW'(12'h600 + k)] = 8'(k * 5 + 3);
    prep(12'h600, 256, 12'h9C3);
    kick(12'h600, 256, 12'h9C3);
    wait_done();
    verify(12'h600, 256, 12'h9C3);

    // Explicit page-crossing indices
    fill_tbl(12'h3F8, 1);
    mem[12'h500] = 8'hFF; mem[12'h501] = 8'h08;
    mem[12'h502] = 8'h07; mem[12'h503] = 8'h00;
    prep(12'h500, 4, 12'h3F8);
    kick(12'h500, 4, 12'h3F8);
    wait_done();
    verify(12'h500, 4, 12'h3F8);
    chk("R8 table read address for index 08", log_addr[4], 12'h400);
    chk("R8 entry past page boundary", mem[12'h501], tbl_fn(1, 8));
    chk("R8 last entry of table", mem[12'h500], tbl_fn(1, 255));

    // Zero length
    prep(12'h700, 0, 12'h100);
    kick(12'h700, 0, 12'h100);
    @(negedge clk);
    chk("R5 done in cycle after start", done, 1);
    @(negedge clk);
    chk("R5 done single cycle", done, 0);
    chk("R5 no memory requests", n_log, 0);
    verify(12'h700, 0, 12'h100);

    // Single byte at the top of a region
    prep(12'h7FF, 1, 12'h100);
    kick(12'h7FF, 1, 12'h100);
    wait_done();
    verify(12'h7FF, 1, 12'h100);

    // Start while busy is ignored
    for (int k = 0; k < 24; k++) mem[AW'(12'h800 + k)] = 8'(k * 11);
    prep(12'h800, 24, 12'h100);
    d0 = n_done;
    kick(12'h800, 24, 12'h100);
    repeat (10) @(negedge clk);
    @(posedge clk); #1;
    start = 1'b1; start_buf = 12'h880; start_len = LW'(8); start_tbl = 12'h9C3;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done();
    verify(12'h800, 24, 12'h100);
    repeat (50) @(negedge clk);
    chk("R6 exactly one done for run plus ignored start", n_done - d0, 1);
    chk("R6 engine idle after ignored start", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule